// File: doc/BRIEF.md
# Dual-Channel Conversion Sequencer

This block is the digital control core of a two-channel sampling converter. An active-low start strobe launches a conversion, and its falling edge is the event that counts. A conversion is one acquire phase followed by the conversion of channel A and then the conversion of channel B. The block raises a busy flag for the whole sequence. It gives a one-clock end-of-conversion pulse when the channel A result is latched, and it drops busy when the channel B result is latched. Each phase length is a parameter counted in clock cycles.

The analog converter is replaced by a fixed-latency stub. At the end of the acquire phase, the stub samples both channel inputs at once. It returns each sample as that channel's result when that channel's conversion phase ends. A running conversion cannot be retriggered by a start edge or stopped by power-down; a power-down request made while busy is held and applied when busy falls. A synchronous abort input cancels a conversion at once. In impulse mode, a start line that is still low when busy falls makes the block time its own acquire phase and then begin the next conversion without a new edge.

Top module: `dual_conv_seq`

## Requirements
- R1: While rst_ni is low and after it is released, busy_o, eoc_o and pwr_dn_o are 0 and res_a_o and res_b_o are all zero.
- R2: A conversion is launched at the first rising clock edge at which start_ni is sampled 0, provided it was sampled 1 at the previous edge and the block is idle with pwr_dn_o at 0. busy_o is 1 from that edge onward.
- R3: After launch, busy_o stays 1 for exactly ACQ_CYC+CONV_A_CYC+CONV_B_CYC cycles. eoc_o is a single-cycle pulse that appears ACQ_CYC+CONV_A_CYC cycles after the launch edge, and only while busy_o is 1.
- R4: Both channel inputs are sampled at the edge where the acquire phase ends. res_a_o changes only together with the eoc_o pulse, and res_b_o changes only at the edge where busy_o falls. Input changes after the acquire phase do not affect the results.
- R5: Falling edges of start_ni while busy_o is 1 neither restart nor lengthen the running conversion.
- R6: pwr_dn_i asserted while busy_o is 1 does not shorten the conversion. pwr_dn_o rises at the same edge at which busy_o falls, and busy_o is never 1 while pwr_dn_o is 1.
- R7: While idle, pwr_dn_o follows pwr_dn_i with one cycle of delay. Start edges seen while pwr_dn_o is 1 launch nothing.
- R8: abort_i sampled 1 forces busy_o and eoc_o to 0 at that edge and leaves both results unchanged. A start line still low afterwards does not relaunch, even in impulse mode.
- R9: With impulse_i at 1 and start_ni at 0 when busy_o falls, busy_o stays 0 for exactly ACQ_CYC cycles and then rises again. The new conversion samples the inputs at the end of that self-timed acquire phase.
- R10: With impulse_i at 0, a start_ni held low after a conversion completes does not launch another one.
- R11: A start_ni held low from reset release onward launches nothing, because a high-to-low transition is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_ni | input | 1 | Active-low start strobe; a falling edge launches a conversion |
| pwr_dn_i | input | 1 | Power-down request |
| abort_i | input | 1 | Synchronous conversion abort, returns to idle |
| impulse_i | input | 1 | 1 selects impulse mode (self-restart), 0 normal mode |
| smp_a_i | input | DW | Channel A sample presented to the conversion stub |
| smp_b_i | input | DW | Channel B sample presented to the conversion stub |
| busy_o | output | 1 | High from launch until the channel B result is latched |
| eoc_o | output | 1 | One-cycle pulse when the channel A result is latched |
| res_a_o | output | DW | Channel A holding register |
| res_b_o | output | DW | Channel B holding register |
| pwr_dn_o | output | 1 | Power-down applied |

## Verification
The bench counts busy and end-of-conversion cycle by cycle from the launch edge. A phase counter that is off by one therefore shows up as an early or late pulse, or as a busy window of the wrong length. It changes the sample inputs just after the acquire phase ends and injects a second start edge mid-conversion. A design that sampled late would return the new values, and one that honoured the second edge would stretch busy. Power-down is raised while busy and while idle. A design that let it cut a conversion short, or dropped the held request, would show at pwr_dn_o and busy_o. Start held low through reset, abort with start still low in impulse mode, and start held low in normal mode all target designs that launch on a level instead of an edge.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int unsigned NCH = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ACQ,
    PH_AUTO_ACQ,
    PH_CONV_A,
    PH_CONV_B
  } phase_e;
endpackage

// File: rtl/dcs_start_detect.sv
module dcs_start_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_ni,
  output logic fall_o
);
  // reset low: a line held low from reset never reads as an edge
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= start_ni;
  end

  assign fall_o = prev_q & ~start_ni;
endmodule

// File: rtl/dcs_phase_timer.sv
module dcs_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dcs_conv_stub.sv
module dcs_conv_stub
  import dcs_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hold_i,
  input  logic [NCH-1:0]          latch_i,
  input  logic [NCH-1:0][DW-1:0]  smp_i,
  output logic [NCH-1:0][DW-1:0]  res_o
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] hold_q;
    logic [DW-1:0] res_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q <= '0;
        res_q  <= '0;
      end else begin
        if (hold_i)      hold_q <= smp_i[ch];
        if (latch_i[ch]) res_q  <= hold_q;
      end
    end

    assign res_o[ch] = res_q;
  end
endmodule

// File: rtl/dual_conv_seq.sv
module dual_conv_seq
  import dcs_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned ACQ_CYC    = 4,
  parameter int unsigned CONV_A_CYC = 6,
  parameter int unsigned CONV_B_CYC = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_ni,
  input  logic          pwr_dn_i,
  input  logic          abort_i,
  input  logic          impulse_i,
  input  logic [DW-1:0] smp_a_i,
  input  logic [DW-1:0] smp_b_i,
  output logic          busy_o,
  output logic          eoc_o,
  output logic [DW-1:0] res_a_o,
  output logic [DW-1:0] res_b_o,
  output logic          pwr_dn_o
);
  localparam int unsigned MAX_A  = (ACQ_CYC > CONV_A_CYC) ? ACQ_CYC : CONV_A_CYC;
  localparam int unsigned MAX_CY = (MAX_A > CONV_B_CYC) ? MAX_A : CONV_B_CYC;
  localparam int unsigned CW     = $clog2(MAX_CY + 1);
  localparam logic [CW-1:0] ACQ_LD = CW'(ACQ_CYC - 1);
  localparam logic [CW-1:0] CA_LD  = CW'(CONV_A_CYC - 1);
  localparam logic [CW-1:0] CB_LD  = CW'(CONV_B_CYC - 1);

  phase_e phase_q, phase_d;
  logic start_fall, t_done, t_load;
  logic [CW-1:0] t_val;
  logic hold, latch_a, latch_b, launch, busy_end;
  logic pd_q, pend_q, eoc_q;
  logic [NCH-1:0][DW-1:0] smp, res;

  dcs_start_detect u_start (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_ni (start_ni),
    .fall_o   (start_fall)
  );

  dcs_phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .done_o     (t_done)
  );

  assign smp[0] = smp_a_i;
  assign smp[1] = smp_b_i;

  dcs_conv_stub #(.DW(DW)) u_stub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (hold),
    .latch_i ({latch_b, latch_a}),
    .smp_i   (smp),
    .res_o   (res)
  );

  always_comb begin
    phase_d  = phase_q;
    t_load   = 1'b0;
    t_val    = '0;
    hold     = 1'b0;
    latch_a  = 1'b0;
    latch_b  = 1'b0;
    launch   = 1'b0;
    busy_end = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_fall && !pd_q) begin
          phase_d = PH_ACQ;
          t_load  = 1'b1;
          t_val   = ACQ_LD;
          launch  = 1'b1;
        end
      end
      PH_ACQ, PH_AUTO_ACQ: begin
        if (phase_q == PH_AUTO_ACQ && pwr_dn_i) begin
          phase_d = PH_IDLE;
        end else if (t_done) begin
          phase_d = PH_CONV_A;
          t_load  = 1'b1;
          t_val   = CA_LD;
          hold    = 1'b1;
        end
      end
      PH_CONV_A: begin
        if (t_done) begin
          phase_d = PH_CONV_B;
          t_load  = 1'b1;
          t_val   = CB_LD;
          latch_a = 1'b1;
        end
      end
      PH_CONV_B: begin
        if (t_done) begin
          latch_b  = 1'b1;
          busy_end = 1'b1;
          if (impulse_i && !start_ni && !pend_q && !pwr_dn_i) begin
            phase_d = PH_AUTO_ACQ;
            t_load  = 1'b1;
            t_val   = ACQ_LD;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    if (abort_i) begin
      phase_d  = PH_IDLE;
      t_load   = 1'b1;
      t_val    = '0;
      hold     = 1'b0;
      latch_a  = 1'b0;
      latch_b  = 1'b0;
      launch   = 1'b0;
      busy_end = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      eoc_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      eoc_q   <= latch_a;
    end
  end

  // power-down: applied only outside a conversion, held while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (abort_i) begin
      pd_q   <= pwr_dn_i;
      pend_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (launch) pend_q <= pwr_dn_i;
          else        pd_q   <= pwr_dn_i;
        end
        PH_AUTO_ACQ: begin
          if (pwr_dn_i) pd_q <= 1'b1;
        end
        default: begin
          if (busy_end) begin
            pd_q   <= pend_q | pwr_dn_i;
            pend_q <= 1'b0;
          end else if (pwr_dn_i) begin
            pend_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o   = (phase_q == PH_ACQ) || (phase_q == PH_CONV_A) || (phase_q == PH_CONV_B);
  assign eoc_o    = eoc_q;
  assign res_a_o  = res[0];
  assign res_b_o  = res[1];
  assign pwr_dn_o = pd_q;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          abort_i,
  input logic          busy_o,
  input logic          eoc_o,
  input logic [DW-1:0] res_a_o,
  input logic [DW-1:0] res_b_o,
  input logic          pwr_dn_o
);
  assert_eoc_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o);

  assert_eoc_in_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> busy_o);

  assert_res_a_on_eoc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_o |-> $stable(res_a_o));

  assert_res_b_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_o) |-> $stable(res_b_o));

  assert_pd_not_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_o |-> !busy_o);

  assert_abort_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !eoc_o));
endmodule

bind dual_conv_seq dcs_checker #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .abort_i  (abort_i),
  .busy_o   (busy_o),
  .eoc_o    (eoc_o),
  .res_a_o  (res_a_o),
  .res_b_o  (res_b_o),
  .pwr_dn_o (pwr_dn_o)
);

// File: tb/dual_conv_seq_bench.sv
module dual_conv_seq_bench;
  localparam int DW = 16;
  localparam int ACQ = 4;
  localparam int CA  = 6;
  localparam int CB  = 6;
  localparam int TOT = ACQ + CA + CB;
  localparam int NV  = 6;
  // {chan A sample, chan B sample}
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_ffff, 32'h1234_abcd, 32'hffff_0000,
    32'h5a5a_a5a5, 32'h0001_8000, 32'hdead_beef
  };

  logic clk_i = 1'b0;
  logic rst_ni, start_ni, pwr_dn_i, abort_i, impulse_i;
  logic [DW-1:0] smp_a_i, smp_b_i, res_a_o, res_b_o;
  logic busy_o, eoc_o, pwr_dn_o;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dual_conv_seq #(.DW(DW), .ACQ_CYC(ACQ), .CONV_A_CYC(CA), .CONV_B_CYC(CB)) u_dual_conv_seq (
    .clk_i, .rst_ni, .start_ni, .pwr_dn_i, .abort_i, .impulse_i,
    .smp_a_i, .smp_b_i, .busy_o, .eoc_o, .res_a_o, .res_b_o, .pwr_dn_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  // launch edge already sampled; walk one conversion, checking every cycle
  task automatic walk(input logic [15:0] a, input logic [15:0] b, input bit poke);
    for (int j = 1; j <= TOT; j++) begin
      tick();
      chk("R3 busy window", 32'(busy_o), 32'(j < TOT));
      chk("R3 eoc timing", 32'(eoc_o), 32'(j == ACQ + CA));
      if (j == ACQ) begin
        smp_a_i = ~a;  // R4: after sampling edge
        smp_b_i = ~b;
      end
      if (poke && j == 2) start_ni = 1'b1;      // R5 second edge
      if (poke && j == 3) start_ni = 1'b0;
      if (j == ACQ + CA) chk("R4 res_a", 32'(res_a_o), 32'(a));
    end
    chk("R4 res_b", 32'(res_b_o), 32'(b));
  endtask

  task automatic launch(input logic [15:0] a, input logic [15:0] b);
    smp_a_i  = a;
    smp_b_i  = b;
    start_ni = 1'b0;
    tick();
    chk("R2 busy on launch", 32'(busy_o), 32'd1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] ra, rb;
    rst_ni = 1'b0; start_ni = 1'b0; pwr_dn_i = 1'b0; abort_i = 1'b0;
    impulse_i = 1'b1; smp_a_i = 16'h1111; smp_b_i = 16'h2222;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 busy in reset", 32'(busy_o), 32'd0);
    chk("R1 res in reset", {res_a_o, res_b_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    chk("R1 eoc/pd after reset", {30'd0, eoc_o, pwr_dn_o}, 32'd0);
    // R11: start low since reset
    for (int k = 0; k < 6; k++) begin
      tick();
      chk("R11 no launch on level", 32'(busy_o), 32'd0);
    end
    impulse_i = 1'b0;
    start_ni  = 1'b1;
    tick();

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      launch(VEC[v][31:16], VEC[v][15:0]);
      walk(VEC[v][31:16], VEC[v][15:0], v[0]);
      for (int k = 0; k < 4; k++) begin
        tick();
        chk("R10 no normal-mode restart", 32'(busy_o), 32'd0);
      end
      start_ni = 1'b1;
      tick();
    end

    // R6: power-down request during a conversion
    launch(16'h0a0a, 16'h0b0b);
    for (int j = 1; j <= TOT; j++) begin
      tick();
      pwr_dn_i = (j == 3);
      chk("R6 busy not cut", 32'(busy_o), 32'(j < TOT));
      if (j < TOT) chk("R6 pd held off", 32'(pwr_dn_o), 32'd0);
    end
    chk("R6 pd applied at busy fall", 32'(pwr_dn_o), 32'd1);
    start_ni = 1'b1;
    tick();
    chk("R7 pd released", 32'(pwr_dn_o), 32'd0);

    // R7: idle power-down blocks launch
    pwr_dn_i = 1'b1;
    tick();
    chk("R7 pd follows", 32'(pwr_dn_o), 32'd1);
    start_ni = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R7 launch blocked", 32'(busy_o), 32'd0);
    end
    pwr_dn_i = 1'b0;
    start_ni = 1'b1;
    tick();
    tick();

    // R8: abort in conv A, impulse mode, start left low
    ra = res_a_o; rb = res_b_o;
    impulse_i = 1'b1;
    launch(16'h7777, 16'h8888);
    for (int j = 1; j <= ACQ + 2; j++) tick();
    abort_i = 1'b1;
    tick();
    abort_i = 1'b0;
    chk("R8 busy cleared", 32'(busy_o), 32'd0);
    chk("R8 results kept", {res_a_o, res_b_o}, {ra, rb});
    for (int k = 0; k < 2 * TOT; k++) begin
      tick();
      chk("R8 no relaunch", {30'd0, busy_o, eoc_o}, 32'd0);
    end
    start_ni = 1'b1;
    tick();

    // R9: impulse self-restart
    launch(16'h4321, 16'h8765);
    walk(16'h4321, 16'h8765, 1'b0);
    smp_a_i = 16'hc0c0;
    smp_b_i = 16'hd0d0;
    for (int j = 1; j <= ACQ; j++) begin
      chk("R9 busy low in auto acquire", 32'(busy_o), 32'd0);
      tick();
    end
    chk("R9 auto relaunch", 32'(busy_o), 32'd1);
    start_ni = 1'b1;
    for (int j = 1; j <= CA + CB; j++) begin
      tick();
      if (j == 1) begin
        smp_a_i = 16'h0;
        smp_b_i = 16'h0;
      end
      chk("R9 busy window", 32'(busy_o), 32'(j < CA + CB));
      chk("R9 eoc timing", 32'(eoc_o), 32'(j == CA));
    end
    chk("R9 auto results", {res_a_o, res_b_o}, 32'hc0c0_d0d0);
    for (int k = 0; k < 2 * ACQ; k++) begin
      tick();
      chk("R9 stops when start high", 32'(busy_o), 32'd0);
    end

    done = 1'b1;
    finish_run();
  end
endmodule